// File: doc/BRIEF.md
# Write Enable and Block Protection Guard

This block sits beside the command decoder of a small serial memory. It holds the write-enable latch and two block-protect bits, and decides whether a data write or a status write may start. The decoder presents single-cycle strobes for "enable writes", "disable writes", "commit data write" (with its target address) and "commit status write" (with its data byte). The block answers with a one-cycle grant pulse. It also forms the 8-bit status byte that a status read returns.

The latch is a three-state machine. `WG_LOCKED` means writes are disabled. `WG_ARMED` means writes are enabled and no cycle is running. `WG_CYCLE` means a cycle has been granted and the block is waiting for the programming timer to end. The transitions are:
- `WG_LOCKED`→`WG_ARMED` on an enable strobe while the protect pin is high and the array is not busy.
- `WG_ARMED`→`WG_LOCKED` on a disable strobe, or when the protect pin is low.
- `WG_ARMED`→`WG_CYCLE` when a commit is accepted.
- `WG_CYCLE`→`WG_LOCKED` on the end-of-cycle pulse.

No other transition exists.

Top module: `wr_guard`

## Requirements
- R1: After reset the latch is clear, the protect level is 00, the grant is low and status reads 0x00.
- R2: An enable strobe sets the latch only while `wp_ok` is high. With `wp_ok` low the latch stays clear.
- R3: A disable strobe clears a set latch, whatever the level of `wp_ok`.
- R4: `wp_ok` going low clears a set latch, and it stays clear after `wp_ok` returns high.
- R5: A data-write commit pulses `grant` for exactly one cycle, in the cycle after the strobe. This happens only when all of these hold: the latch is set, `wp_ok` is high, `busy` is low, and the address lies outside the protected range. Otherwise `grant` stays low.
- R6: The protected range for the 9-bit address depends on `bp_level`:
  - 00 protects nothing.
  - 01 protects 0x180–0x1FF.
  - 10 protects 0x100–0x1FF.
  - 11 protects 0x000–0x1FF.
  - For a page write the check uses the page base, which is the address with its two low bits cleared.
- R7: A granted status write loads `bp_level` from data bits 3:2, and its other data bits have no effect. A status write is not limited by the address range. Without a grant, `bp_level` is unchanged.
- R8: The end-of-cycle pulse that closes a granted cycle clears the latch.
- R9: While `busy` is low, status is {0000, bp_level[1:0], latch, 0}.
- R10: While `busy` is high, status reads 0xFF.
- R11: While a granted cycle is pending, enable, data-write and status-write strobes produce no grant and do not change `bp_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_ok | input | 1 | Write-protect pin; high permits writes |
| cmd_set_en | input | 1 | Enable-writes strobe |
| cmd_clr_en | input | 1 | Disable-writes strobe |
| cmd_wr | input | 1 | Data-write commit strobe |
| wr_addr | input | AW | Target address of the data write |
| cmd_wsr | input | 1 | Status-write commit strobe |
| wsr_data | input | 8 | Data byte of the status write |
| busy | input | 1 | Programming cycle in progress |
| cycle_done | input | 1 | End-of-cycle pulse from the program timer |
| grant | output | 1 | One-cycle grant for a commit |
| status | output | 8 | Status byte for reads |
| bp_level | output | 2 | Current block-protect bits |

## Verification
A wrong latch state shows up at once in status bit 1, and one cycle later in a grant that appears or goes missing on the next commit. A wrong protect decode shows up as a wrong grant on the first address beyond a range boundary. For that reason the bench sweeps every address at every level. A latch that fails to clear after a cycle is visible in status in the cycle after the end pulse. A status-write leak is visible in `bp_level` straight after the strobe.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
    typedef enum logic [1:0] {
        WG_LOCKED = 2'd0,
        WG_ARMED  = 2'd1,
        WG_CYCLE  = 2'd2
    } wg_state_e;

    localparam int unsigned BP_W   = 2;
    localparam int unsigned STAT_W = 8;
endpackage

// File: rtl/wrg_range_cmp.sv
module wrg_range_cmp #(
    parameter int unsigned AW        = 9,
    parameter int unsigned PAGE_BITS = 2
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    level,
    output logic          hit
);
    localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));
    localparam logic [AW-1:0] QTR_BASE  = AW'(3) << (AW - 2);
    localparam logic [AW-1:0] HALF_BASE = AW'(1) << (AW - 1);

    logic [AW-1:0] base;

    always_comb begin
        base = addr & PAGE_MASK;
        unique case (level)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (base >= QTR_BASE);
            2'b10:   hit = (base >= HALF_BASE);
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wrg_status_fmt.sv
module wrg_status_fmt (
    input  logic       busy,
    input  logic       latch_on,
    input  logic [1:0] bp,
    output logic [7:0] status
);
    always_comb begin
        if (busy) status = 8'hFF;
        else      status = {4'b0000, bp, latch_on, 1'b0};
    end
endmodule

// File: rtl/wrg_latch_fsm.sv
module wrg_latch_fsm
    import wrg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_ok,
    input  logic set_en,
    input  logic clr_en,
    input  logic req_wr,
    input  logic req_wsr,
    input  logic wr_hit,
    input  logic busy,
    input  logic cycle_done,
    output logic latch_on,
    output logic cyc_pending,
    output logic accept,
    output logic grant
);
    wg_state_e state_q, state_d;

    always_comb begin
        accept = (state_q == WG_ARMED) && wp_ok && !clr_en && !busy &&
                 (req_wsr || (req_wr && !wr_hit));
        state_d = state_q;
        unique case (state_q)
            WG_LOCKED: if (set_en && wp_ok && !busy) state_d = WG_ARMED;
            WG_ARMED: begin
                if (clr_en || !wp_ok) state_d = WG_LOCKED;
                else if (accept)      state_d = WG_CYCLE;
            end
            WG_CYCLE:  if (cycle_done) state_d = WG_LOCKED;
            default:   state_d = WG_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WG_LOCKED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant <= 1'b0;
        else        grant <= accept;
    end

    assign latch_on    = (state_q != WG_LOCKED);
    assign cyc_pending = (state_q == WG_CYCLE);
endmodule

// File: rtl/wr_guard.sv
module wr_guard
    import wrg_pkg::*;
#(
    parameter int unsigned AW        = 9,
    parameter int unsigned PAGE_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_ok,
    input  logic          cmd_set_en,
    input  logic          cmd_clr_en,
    input  logic          cmd_wr,
    input  logic [AW-1:0] wr_addr,
    input  logic          cmd_wsr,
    input  logic [7:0]    wsr_data,
    input  logic          busy,
    input  logic          cycle_done,
    output logic          grant,
    output logic [7:0]    status,
    output logic [1:0]    bp_level
);
    logic wr_hit, latch_on, cyc_pending, accept;
    logic [BP_W-1:0] bp_q;
    wire unused_wsr_bits = ^{wsr_data[7:4], wsr_data[1:0]};

    wrg_range_cmp #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_range (
        .addr(wr_addr), .level(bp_q), .hit(wr_hit)
    );

    wrg_latch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wp_ok(wp_ok),
        .set_en(cmd_set_en), .clr_en(cmd_clr_en),
        .req_wr(cmd_wr), .req_wsr(cmd_wsr), .wr_hit(wr_hit),
        .busy(busy), .cycle_done(cycle_done),
        .latch_on(latch_on), .cyc_pending(cyc_pending),
        .accept(accept), .grant(grant)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bp_q <= '0;
        else if (accept && cmd_wsr) bp_q <= wsr_data[3:2];
    end

    wrg_status_fmt u_fmt (
        .busy(busy), .latch_on(latch_on), .bp(bp_q), .status(status)
    );

    assign bp_level = bp_q;
endmodule

// File: rtl/wrg_checker.sv
module wrg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_ok,
    input logic       cmd_clr_en,
    input logic       cmd_wsr,
    input logic       busy,
    input logic       cycle_done,
    input logic       grant,
    input logic [1:0] bp_level,
    input logic       latch_on,
    input logic       cyc_pending
);
    p_set_needs_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_on && !wp_ok) |=> !latch_on);

    p_clear_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_en && !cyc_pending) |=> !latch_on);

    p_pin_low_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_ok && !cyc_pending) |=> !latch_on);

    p_grant_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ($past(latch_on) && $past(wp_ok) && !$past(busy)));

    p_grant_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    p_bp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wsr |=> $stable(bp_level));

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_pending && cycle_done) |=> !latch_on);

    p_no_grant_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pending |=> !grant);
endmodule

bind wr_guard wrg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wp_ok(wp_ok), .cmd_clr_en(cmd_clr_en),
    .cmd_wsr(cmd_wsr), .busy(busy), .cycle_done(cycle_done),
    .grant(grant), .bp_level(bp_level), .latch_on(latch_on),
    .cyc_pending(cyc_pending)
);

// File: tb/tb_wr_guard.sv
module tb_wr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wp_ok = 1'b1, cmd_set_en = 1'b0, cmd_clr_en = 1'b0, cmd_wr = 1'b0, cmd_wsr = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wsr_data = '0;
    logic busy = 1'b0, cycle_done = 1'b0;
    logic grant;
    logic [7:0] status;
    logic [1:0] bp_level;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_guard #(.AW(AW), .PAGE_BITS(2)) dut (
        .clk(clk), .rst_n(rst_n), .wp_ok(wp_ok), .cmd_set_en(cmd_set_en),
        .cmd_clr_en(cmd_clr_en), .cmd_wr(cmd_wr), .wr_addr(wr_addr),
        .cmd_wsr(cmd_wsr), .wsr_data(wsr_data), .busy(busy),
        .cycle_done(cycle_done), .grant(grant), .status(status), .bp_level(bp_level)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_latch();
        cmd_set_en = 1'b1; tick(); cmd_set_en = 1'b0;
    endtask

    task automatic finish_cycle(input logic [1:0] lvl);
        busy = 1'b1; tick();
        check("R10 busy status", status, 8'hFF);
        cycle_done = 1'b1; busy = 1'b0; tick(); cycle_done = 1'b0;
        check("R8 latch cleared after cycle", status, {4'b0, lvl, 2'b00});
    endtask

    function automatic bit is_prot(input int lvl, input int a);
        int base = a - (a % 4);
        return (lvl == 3) || (lvl == 2 && base >= 256) || (lvl == 1 && base >= 384);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur;
        tick(); tick();
        check("R1 status after reset", status, 8'h00);
        check("R1 grant after reset", {7'b0, grant}, 8'h00);
        check("R1 bp after reset", {6'b0, bp_level}, 8'h00);
        rst_n = 1'b1; tick();

        // R2: enable refused while pin low
        wp_ok = 1'b0; set_latch(); wp_ok = 1'b1;
        check("R2 set refused with pin low", status, 8'h00);
        set_latch();
        check("R2 set accepted with pin high", status, 8'h02);

        // R4: pin low clears latch
        wp_ok = 1'b0; tick(); wp_ok = 1'b1; tick();
        check("R4 pin low clears latch", status, 8'h00);

        // R3: clear with pin high
        set_latch();
        cmd_clr_en = 1'b1; tick(); cmd_clr_en = 1'b0;
        check("R3 clear command", status, 8'h00);

        // R5/R7: status write without latch is ignored
        cmd_wsr = 1'b1; wsr_data = 8'hFF; tick(); cmd_wsr = 1'b0;
        check("R7 no grant without latch", {7'b0, grant}, 8'h00);
        check("R7 bp unchanged without grant", {6'b0, bp_level}, 8'h00);

        // R5: write with pin low is refused
        set_latch();
        wp_ok = 1'b0; cmd_wr = 1'b1; wr_addr = 9'h010; tick(); cmd_wr = 1'b0; wp_ok = 1'b1;
        check("R5 no grant with pin low", {7'b0, grant}, 8'h00);

        // R11: requests during a pending cycle are ignored
        set_latch();
        cmd_wr = 1'b1; wr_addr = 9'h020; tick(); cmd_wr = 1'b0;
        check("R5 grant on open address", {7'b0, grant}, 8'h01);
        tick();
        check("R5 grant lasts one cycle", {7'b0, grant}, 8'h00);
        cmd_wsr = 1'b1; wsr_data = 8'h0C; cmd_set_en = 1'b1; tick();
        cmd_wsr = 1'b0; cmd_set_en = 1'b0;
        check("R11 no grant while pending", {7'b0, grant}, 8'h00);
        check("R11 bp unchanged while pending", {6'b0, bp_level}, 8'h00);
        finish_cycle(2'b00);

        // Sweep every level and every address
        for (int lvl = 0; lvl < 4; lvl++) begin
            cur = lvl[1:0];
            set_latch();
            cmd_wsr = 1'b1; wsr_data = {4'hA, cur, 2'b11}; tick(); cmd_wsr = 1'b0;
            check("R7 status write granted", {7'b0, grant}, 8'h01);
            check("R7 bp loaded from bits 3:2", {6'b0, bp_level}, {6'b0, cur});
            finish_cycle(cur);
            check("R9 idle status format", status, {4'b0, cur, 2'b00});
            for (int a = 0; a < 512; a++) begin
                set_latch();
                check("R9 armed status format", status, {4'b0, cur, 2'b10});
                cmd_wr = 1'b1; wr_addr = a[AW-1:0]; tick(); cmd_wr = 1'b0;
                if (is_prot(lvl, a)) begin
                    check("R6 protected address refused", {7'b0, grant}, 8'h00);
                    cmd_clr_en = 1'b1; tick(); cmd_clr_en = 1'b0;
                    check("R3 clear after refused write", status, {4'b0, cur, 2'b00});
                end else begin
                    check("R6 open address granted", {7'b0, grant}, 8'h01);
                    finish_cycle(cur);
                end
            end
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule